// File: doc/BRIEF.md
# Macro Sequencer Core with Delay Slots

This block executes short programs of 32-bit macro instructions held in a local code memory. It has eight 32-bit general registers and consumes argument words from an upstream parameter stream. Its only visible effect is a stream of method/data writes towards a downstream engine. A run begins with a `start` pulse that carries the byte address of the first instruction. That address also serves as the base for every branch target. The run ends with a one-cycle `done` pulse.

Each instruction takes two cycles, one to fetch and one to execute. The code memory is read synchronously: the address is presented in the fetch cycle and the word is used in the execute cycle. Conditional branches normally run one delay-slot instruction before they redirect, and an instruction bit can turn that slot off. When an instruction needs a parameter and none is available, the sequencer holds in place until the stream supplies one. If the stream reports that it is exhausted, the instruction reads zero instead.

Top module: `mseq_core`

Instruction word fields: op = bits 2:0; condition-sense = bit 3; no-slot = bit 5; exit = bit 7; rD = bits 10:8; rA = bits 13:11; rB = bits 16:14; ALU function = bits 21:17; bitfield source position = bits 21:17; field size-minus-one = bits 26:22; bitfield destination position = bits 31:27; immediate = bits 31:14 (signed); method = bits 31:20.

## Requirements
- R1: While reset is high and after it is released, the outputs busy, done, err, eng_valid and prm_ready are all low until a start pulse arrives.
- R2: A start pulse while idle raises busy on the next edge. The first parameter word is then loaded into r1 before the first fetch. r0 always reads zero, and writes to it are dropped.
- R3: Op 0 writes rD with f(rA, rB), where f is selected by the function field: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 A and not B, 6 A or not B, 7 xnor, 8 shift left by B[4:0], 9 logical shift right by B[4:0], 10 unsigned less-than (1/0), 11 equal (1/0), 12 nand. Op 1 writes rD with rA plus the sign-extended immediate.
- R4: A function code of 13 to 31 in op 0 writes no register. It sets err, ends the run with a done pulse and emits no further engine write. err stays set until the next start.
- R5: Op 2 (field move) takes (rB >> srcpos) AND mask with a logical shift, where the mask has size+1 ones. It clears those bits of rA at dstpos, inserts the field there and writes the result to rD.
- R6: Op 3 writes ((rB >> rA[4:0]) AND mask) << dstpos. Op 4 writes ((rB >> srcpos) AND mask) << rA[4:0]. Both shifts right are logical.
- R7: Op 7 is a branch, taken when rA is zero (bit 3 clear) or when rA is non-zero (bit 3 set). With bit 5 clear, the instruction that follows the branch runs before the redirect.
- R8: With bit 5 set, a taken branch redirects at once and the following instruction does not run.
- R9: The branch target is the start byte address plus the sign-extended immediate times 4. The program counter otherwise advances by 4 bytes per instruction.
- R10: Op 6 writes rD with the next parameter word. While no word is offered and prm_end is low, the sequencer stalls with busy high. When prm_end is high and no word is offered, the instruction reads zero.
- R11: An instruction with bit 7 set lets exactly one more instruction run. The run then ends with a done pulse that lasts one cycle, and busy is low in that cycle.
- R12: Op 5 emits one engine write carrying method = bits 31:20 and data = rB. It appears on eng_valid one cycle after the execute edge of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken while idle) |
| start_addr | input | PC_W | Byte address of first instruction and branch base |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Last run stopped on an illegal ALU code |
| code_addr | output | PC_W-2 | Word address to the code memory |
| code_data | input | 32 | Code word, one cycle after its address |
| prm_valid | input | 1 | A parameter word is offered |
| prm_ready | output | 1 | The sequencer takes the offered word |
| prm_data | input | 32 | Parameter word |
| prm_end | input | 1 | The parameter stream has no more words |
| eng_valid | output | 1 | Engine write strobe |
| eng_method | output | 12 | Engine method index |
| eng_data | output | 32 | Engine write data |

## Verification
The bench builds the core with PC_W = 9, which gives a 128-word code memory. That is enough to hold separate programs at byte addresses 0, 32, 64, 128 and 192. Non-zero start addresses make the branch base observable. A three-pass countdown loop runs its delay slot once per pass and once more on the fall-through, so the slot and no-slot variants produce different write sequences. Field tests use a source word with bit 31 set, which separates a logical shift from an arithmetic one.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int XLEN    = 32;
    localparam int NREG    = 8;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int FN_W    = 5;
    localparam int POS_W   = 5;
    localparam int IMM_W   = 18;
    localparam int METH_W  = 12;
    localparam logic [FN_W-1:0] FN_LAST = 5'd12;

    typedef enum logic [2:0] {
        OP_ALU   = 3'd0,
        OP_ADDI  = 3'd1,
        OP_BFMOV = 3'd2,
        OP_BFXI  = 3'd3,
        OP_BFXR  = 3'd4,
        OP_SEND  = 3'd5,
        OP_PARM  = 3'd6,
        OP_BRA   = 3'd7
    } mop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRELOAD,
        ST_FETCH,
        ST_EXEC
    } mst_e;

    typedef struct packed {
        mop_e                op;
        logic                ne;
        logic                noslot;
        logic                xit;
        logic [RIDX_W-1:0]   rd;
        logic [RIDX_W-1:0]   ra;
        logic [RIDX_W-1:0]   rb;
        logic [FN_W-1:0]     fn;
        logic [POS_W-1:0]    spos;
        logic [POS_W-1:0]    size;
        logic [POS_W-1:0]    dpos;
        logic [IMM_W-1:0]    imm;
        logic [METH_W-1:0]   meth;
    } minstr_t;

    function automatic minstr_t mseq_decode(input logic [XLEN-1:0] w);
        minstr_t d;
        d.op     = mop_e'(w[2:0]);
        d.ne     = w[3];
        d.noslot = w[5];
        d.xit    = w[7];
        d.rd     = w[10:8];
        d.ra     = w[13:11];
        d.rb     = w[16:14];
        d.fn     = w[21:17];
        d.spos   = w[21:17];
        d.size   = w[26:22];
        d.dpos   = w[31:27];
        d.imm    = w[31:14];
        d.meth   = w[31:20];
        return d;
    endfunction

    function automatic logic [XLEN-1:0] mseq_mask(input logic [POS_W-1:0] sz);
        logic [XLEN-1:0] m;
        if (sz == '1)
            m = '1;
        else
            m = (XLEN'(1) << (sz + POS_W'(1))) - XLEN'(1);
        return m;
    endfunction

    function automatic logic [XLEN-1:0] mseq_sext(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/mseq_regfile.sv
module mseq_regfile
    import mseq_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [W-1:0]  ra_q,
    output logic [W-1:0]  rb_q
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign ra_q = (ra == '0) ? '0 : regs[ra];
    assign rb_q = (rb == '0) ? '0 : regs[rb];

endmodule

// File: rtl/mseq_alu.sv
module mseq_alu
    import mseq_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [FN_W-1:0] fn,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y,
    output logic            bad
);

    localparam int SH_W = $clog2(W);

    always_comb begin
        bad = 1'b0;
        unique case (fn)
            5'd0:  y = a + b;
            5'd1:  y = a - b;
            5'd2:  y = a & b;
            5'd3:  y = a | b;
            5'd4:  y = a ^ b;
            5'd5:  y = a & ~b;
            5'd6:  y = a | ~b;
            5'd7:  y = ~(a ^ b);
            5'd8:  y = a << b[SH_W-1:0];
            5'd9:  y = a >> b[SH_W-1:0];
            5'd10: y = W'(a < b);
            5'd11: y = W'(a == b);
            5'd12: y = ~(a & b);
            default: begin
                y   = '0;
                bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mseq_bitfield.sv
module mseq_bitfield
    import mseq_pkg::*;
#(
    parameter int W = XLEN
) (
    input  mop_e             op,
    input  logic [W-1:0]     ra_v,
    input  logic [W-1:0]     rb_v,
    input  logic [POS_W-1:0] spos,
    input  logic [POS_W-1:0] size,
    input  logic [POS_W-1:0] dpos,
    output logic [W-1:0]     y
);

    logic [W-1:0]     msk;
    logic [POS_W-1:0] rsh;

    assign msk = mseq_mask(size);
    assign rsh = ra_v[POS_W-1:0];

    always_comb begin
        case (op)
            OP_BFMOV: y = (ra_v & ~(msk << dpos)) | (((rb_v >> spos) & msk) << dpos);
            OP_BFXI:  y = ((rb_v >> rsh) & msk) << dpos;
            OP_BFXR:  y = ((rb_v >> spos) & msk) << rsh;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
#(
    parameter int PC_W = 10,
    localparam int CA_W = PC_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PC_W-1:0]   start_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CA_W-1:0]   code_addr,
    input  logic [XLEN-1:0]   code_data,
    input  logic              prm_valid,
    output logic              prm_ready,
    input  logic [XLEN-1:0]   prm_data,
    input  logic              prm_end,
    output logic              eng_valid,
    output logic [METH_W-1:0] eng_method,
    output logic [XLEN-1:0]   eng_data
);

    mst_e            st;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] base;
    logic            slot_pend;
    logic [PC_W-1:0] slot_tgt;
    logic            exit_pend;

    minstr_t         dec;
    logic [XLEN-1:0] a_v, b_v, alu_y, bf_y, res;
    logic            alu_bad;
    logic            in_exec, prm_avail, stall, bad, step, wr_op;
    logic [XLEN-1:0] prm_word;
    logic            rf_we;
    logic [RIDX_W-1:0] rf_wa;
    logic [XLEN-1:0] rf_wd;
    logic            taken;
    logic [XLEN-1:0] off_full;
    logic [PC_W-1:0] tgt;

    assign dec       = mseq_decode(code_data);
    assign code_addr = pc[PC_W-1:2];
    assign busy      = (st != ST_IDLE);

    mseq_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (rf_wd),
        .ra   (dec.ra),
        .rb   (dec.rb),
        .ra_q (a_v),
        .rb_q (b_v)
    );

    mseq_alu #(.W(XLEN)) u_alu (
        .fn  (dec.fn),
        .a   (a_v),
        .b   (b_v),
        .y   (alu_y),
        .bad (alu_bad)
    );

    mseq_bitfield #(.W(XLEN)) u_bf (
        .op   (dec.op),
        .ra_v (a_v),
        .rb_v (b_v),
        .spos (dec.spos),
        .size (dec.size),
        .dpos (dec.dpos),
        .y    (bf_y)
    );

    // Parameter stream: zero once the stream is exhausted
    assign prm_avail = prm_valid | prm_end;
    assign prm_word  = prm_valid ? prm_data : '0;
    assign in_exec   = (st == ST_EXEC);
    assign stall     = in_exec && (dec.op == OP_PARM) && !prm_avail;
    assign bad       = in_exec && (dec.op == OP_ALU) && alu_bad;
    assign step      = in_exec && !stall && !bad;
    assign prm_ready = (st == ST_PRELOAD) || (in_exec && dec.op == OP_PARM);

    always_comb begin
        wr_op = 1'b1;
        case (dec.op)
            OP_ALU:                    res = alu_y;
            OP_ADDI:                   res = a_v + mseq_sext(dec.imm);
            OP_BFMOV, OP_BFXI, OP_BFXR: res = bf_y;
            OP_PARM:                   res = prm_word;
            default: begin
                res   = '0;
                wr_op = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (st == ST_PRELOAD) begin
            rf_we = prm_avail;
            rf_wa = RIDX_W'(1);
            rf_wd = prm_word;
        end else begin
            rf_we = step && wr_op;
            rf_wa = dec.rd;
            rf_wd = res;
        end
    end

    // Branch decision and target
    assign taken    = (dec.op == OP_BRA) && (dec.ne ? (a_v != '0) : (a_v == '0));
    assign off_full = mseq_sext(dec.imm) << 2;
    assign tgt      = base + off_full[PC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            pc         <= '0;
            base       <= '0;
            slot_pend  <= 1'b0;
            slot_tgt   <= '0;
            exit_pend  <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            eng_valid  <= 1'b0;
            eng_method <= '0;
            eng_data   <= '0;
        end else begin
            done      <= 1'b0;
            eng_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        pc        <= {start_addr[PC_W-1:2], 2'b00};
                        base      <= {start_addr[PC_W-1:2], 2'b00};
                        slot_pend <= 1'b0;
                        exit_pend <= 1'b0;
                        err       <= 1'b0;
                        st        <= ST_PRELOAD;
                    end
                end
                ST_PRELOAD: begin
                    if (prm_avail) st <= ST_FETCH;
                end
                ST_FETCH: begin
                    st <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (bad) begin
                        err       <= 1'b1;
                        done      <= 1'b1;
                        slot_pend <= 1'b0;
                        st        <= ST_IDLE;
                    end else if (!stall) begin
                        if (dec.op == OP_SEND) begin
                            eng_valid  <= 1'b1;
                            eng_method <= dec.meth;
                            eng_data   <= b_v;
                        end
                        if (slot_pend) begin
                            pc        <= slot_tgt;
                            slot_pend <= 1'b0;
                        end else if (taken && dec.noslot) begin
                            pc <= tgt;
                        end else if (taken) begin
                            pc        <= pc + PC_W'(4);
                            slot_pend <= 1'b1;
                            slot_tgt  <= tgt;
                        end else begin
                            pc <= pc + PC_W'(4);
                        end
                        if (exit_pend) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            exit_pend <= dec.xit;
                            st        <= ST_FETCH;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mseq_chk.sv
module mseq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic prm_ready,
    input logic eng_valid
);

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R4
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    // R10
    prm_ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        prm_ready |-> busy);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R12
    eng_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        eng_valid |-> $past(busy));

endmodule

bind mseq_core mseq_chk u_mseq_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .prm_ready (prm_ready),
    .eng_valid (eng_valid)
);

// File: tb/tb_mseq_core.sv
module tb_mseq_core;

    localparam int PCW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [PCW-1:0] start_addr = '0;
    logic        busy, done, err;
    logic [PCW-3:0] code_addr;
    logic [31:0] code_data;
    logic        prm_valid, prm_ready, prm_end;
    logic [31:0] prm_data;
    logic        eng_valid;
    logic [11:0] eng_method;
    logic [31:0] eng_data;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    mseq_core #(.PC_W(PCW)) dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .busy(busy), .done(done), .err(err),
        .code_addr(code_addr), .code_data(code_data),
        .prm_valid(prm_valid), .prm_ready(prm_ready), .prm_data(prm_data), .prm_end(prm_end),
        .eng_valid(eng_valid), .eng_method(eng_method), .eng_data(eng_data)
    );

    // code memory model
    logic [31:0] rom [128];
    always_ff @(posedge clk) code_data <= rom[code_addr];

    // parameter source
    logic [31:0] pvals [8];
    int   pcount = 0;
    logic pgate = 1'b1;
    logic pend_in = 1'b0;
    logic pclr = 1'b0;
    int   pidx;
    always_ff @(posedge clk) begin
        if (pclr) pidx <= 0;
        else if (prm_valid && prm_ready) pidx <= pidx + 1;
    end
    assign prm_valid = pgate && (pidx < pcount);
    assign prm_data  = (pidx < 8) ? pvals[pidx[2:0]] : 32'h0;
    assign prm_end   = pend_in;

    // engine write log
    logic [11:0] lm [64];
    logic [31:0] ld [64];
    int ecnt = 0;
    always @(posedge clk) begin
        #2;
        if (eng_valid && ecnt < 64) begin
            lm[ecnt] = eng_method;
            ld[ecnt] = eng_data;
            ecnt = ecnt + 1;
        end
    end

    // instruction encoders
    function automatic logic [31:0] i_alu(input logic [4:0] fn, input logic [2:0] d, a, b, input logic x);
        return {10'd0, fn, b, a, d, x, 4'd0, 3'd0};
    endfunction
    function automatic logic [31:0] i_addi(input logic [2:0] d, a, input logic [17:0] imm, input logic x);
        return {imm, a, d, x, 4'd0, 3'd1};
    endfunction
    function automatic logic [31:0] i_bf(input logic [2:0] op, d, a, b, input logic [4:0] sp, sz, dp, input logic x);
        return {dp, sz, sp, b, a, d, x, 4'd0, op};
    endfunction
    function automatic logic [31:0] i_send(input logic [11:0] m, input logic [2:0] b, input logic x);
        return {m, 3'd0, b, 3'd0, 3'd0, x, 4'd0, 3'd5};
    endfunction
    function automatic logic [31:0] i_parm(input logic [2:0] d, input logic x);
        return {15'd0, 3'd0, d, x, 4'd0, 3'd6};
    endfunction
    function automatic logic [31:0] i_br(input logic [17:0] imm, input logic [2:0] a, input logic ne, nd, x);
        return {imm, a, 3'd0, x, 1'b0, nd, 1'b0, ne, 3'd7};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load2(input int n, input logic [31:0] v0, input logic [31:0] v1);
        pvals[0] = v0;
        pvals[1] = v1;
        pcount   = n;
        pclr     = 1'b1;
        @(negedge clk);
        pclr     = 1'b0;
    endtask

    task automatic kick(input logic [PCW-1:0] sa);
        @(negedge clk);
        start      = 1'b1;
        start_addr = sa;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({req, " run finished"}, 32'(done), 32'd1);
        @(negedge clk);
        check({req, " done single cycle"}, {30'd0, done, busy}, 32'd0);
    endtask

    task automatic chk_wr(input string req, input int idx, input logic [11:0] m, input logic [31:0] d);
        check({req, " method"}, {20'd0, lm[idx]}, {20'd0, m});
        check({req, " data"}, ld[idx], d);
    endtask

    // R3 vectors: {fn, a, b, expected}
    localparam logic [100:0] VEC [13] = '{
        {5'd0,  32'd5,          32'd7,          32'd12},
        {5'd1,  32'd5,          32'd7,          32'hFFFF_FFFE},
        {5'd2,  32'h0000_F0F0,  32'h0000_FF00,  32'h0000_F000},
        {5'd3,  32'h0000_F0F0,  32'h0000_FF00,  32'h0000_FFF0},
        {5'd4,  32'h0000_F0F0,  32'h0000_FF00,  32'h0000_0FF0},
        {5'd5,  32'h0000_F0F0,  32'h0000_FF00,  32'h0000_00F0},
        {5'd6,  32'h0000_F0F0,  32'h0000_FF00,  32'hFFFF_F0FF},
        {5'd7,  32'h0000_F0F0,  32'h0000_FF00,  32'hFFFF_F00F},
        {5'd8,  32'd3,          32'd4,          32'h0000_0030},
        {5'd9,  32'h8000_0000,  32'd31,         32'd1},
        {5'd10, 32'd5,          32'd7,          32'd1},
        {5'd11, 32'd9,          32'd9,          32'd1},
        {5'd12, 32'h0000_F0F0,  32'h0000_FF00,  32'hFFFF_0FFF}
    };

    task automatic set_alu(input logic [4:0] fn);
        rom[0] = i_parm(3'd2, 1'b0);
        rom[1] = i_alu(fn, 3'd3, 3'd1, 3'd2, 1'b0);
        rom[2] = i_send(12'h010, 3'd3, 1'b1);
        rom[3] = i_addi(3'd0, 3'd0, 18'd0, 1'b0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        #(20 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int e0;
        for (int i = 0; i < 128; i++) rom[i] = i_addi(3'd0, 3'd0, 18'd0, 1'b0);

        // r0 / preload program at byte 32
        rom[8]  = i_addi(3'd0, 3'd1, 18'd5, 1'b0);
        rom[9]  = i_send(12'h006, 3'd1, 1'b0);
        rom[10] = i_send(12'h007, 3'd0, 1'b1);
        // field program at byte 64
        rom[16] = i_addi(3'd2, 3'd0, 18'd8, 1'b0);
        rom[17] = i_addi(3'd3, 3'd0, 18'h3FFFF, 1'b0);
        rom[18] = i_bf(3'd2, 3'd3, 3'd3, 3'd1, 5'd28, 5'd7, 5'd4, 1'b0);
        rom[19] = i_send(12'h001, 3'd3, 1'b0);
        rom[20] = i_bf(3'd3, 3'd4, 3'd2, 3'd1, 5'd0, 5'd15, 5'd4, 1'b0);
        rom[21] = i_send(12'h002, 3'd4, 1'b0);
        rom[22] = i_bf(3'd4, 3'd5, 3'd2, 3'd1, 5'd24, 5'd7, 5'd0, 1'b0);
        rom[23] = i_send(12'h003, 3'd5, 1'b1);
        // delay-slot loop at byte 128
        rom[32] = i_addi(3'd2, 3'd0, 18'd3, 1'b0);
        rom[33] = i_send(12'h100, 3'd2, 1'b0);
        rom[34] = i_addi(3'd2, 3'd2, 18'h3FFFF, 1'b0);
        rom[35] = i_br(18'd1, 3'd2, 1'b1, 1'b0, 1'b0);
        rom[36] = i_send(12'h200, 3'd2, 1'b0);
        rom[37] = i_send(12'h300, 3'd2, 1'b1);
        rom[38] = i_send(12'h3FF, 3'd0, 1'b0);
        rom[39] = i_send(12'h555, 3'd0, 1'b0);
        // no-slot loop at byte 192
        rom[48] = i_addi(3'd2, 3'd0, 18'd3, 1'b0);
        rom[49] = i_send(12'h100, 3'd2, 1'b0);
        rom[50] = i_addi(3'd2, 3'd2, 18'h3FFFF, 1'b0);
        rom[51] = i_br(18'd1, 3'd2, 1'b1, 1'b1, 1'b0);
        rom[52] = i_send(12'h200, 3'd2, 1'b0);
        rom[53] = i_send(12'h300, 3'd2, 1'b1);

        set_alu(5'd0);
        pclr = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {27'd0, busy, done, err, eng_valid, prm_ready}, 32'd0);
        rst  = 1'b0;
        pclr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {27'd0, busy, done, err, eng_valid, prm_ready}, 32'd0);

        // R3 table walk
        for (int v = 0; v < 13; v++) begin
            set_alu(VEC[v][100:96]);
            load2(2, VEC[v][95:64], VEC[v][63:32]);
            e0 = ecnt;
            kick(9'd0);
            wait_done("R3");
            check("R3 write count", 32'(ecnt - e0), 32'd1);
            chk_wr($sformatf("R3 fn%0d R12", v), e0, 12'h010, VEC[v][31:0]);
        end

        // R2: preload r1, r0 stays zero
        load2(1, 32'hCAFE_0001, 32'h0);
        e0 = ecnt;
        kick(9'd32);
        wait_done("R2");
        check("R2 write count", 32'(ecnt - e0), 32'd2);
        chk_wr("R2 preload r1", e0, 12'h006, 32'hCAFE_0001);
        chk_wr("R2 r0 zero", e0 + 1, 12'h007, 32'h0);

        // R5 R6 field operations, logical shifts
        load2(1, 32'h8765_4321, 32'h0);
        e0 = ecnt;
        kick(9'd64);
        wait_done("R5");
        check("R5 R6 write count", 32'(ecnt - e0), 32'd3);
        chk_wr("R5 field move", e0, 12'h001, 32'hFFFF_F08F);
        chk_wr("R6 extract shift-imm", e0 + 1, 12'h002, 32'h0006_5430);
        chk_wr("R6 extract shift-reg", e0 + 2, 12'h003, 32'h0000_8700);

        // R7 R9 R11 delay-slot loop at non-zero base
        load2(1, 32'h0, 32'h0);
        e0 = ecnt;
        kick(9'd128);
        wait_done("R7");
        check("R7 R11 write count", 32'(ecnt - e0), 32'd8);
        chk_wr("R7 w0", e0,     12'h100, 32'd3);
        chk_wr("R7 slot w1", e0 + 1, 12'h200, 32'd2);
        chk_wr("R9 w2", e0 + 2, 12'h100, 32'd2);
        chk_wr("R7 slot w3", e0 + 3, 12'h200, 32'd1);
        chk_wr("R9 w4", e0 + 4, 12'h100, 32'd1);
        chk_wr("R7 w5", e0 + 5, 12'h200, 32'd0);
        chk_wr("R11 exit instr", e0 + 6, 12'h300, 32'd0);
        chk_wr("R11 one more", e0 + 7, 12'h3FF, 32'd0);

        // R8 no-slot loop
        load2(1, 32'h0, 32'h0);
        e0 = ecnt;
        kick(9'd192);
        wait_done("R8");
        check("R8 write count", 32'(ecnt - e0), 32'd5);
        chk_wr("R8 w0", e0,     12'h100, 32'd3);
        chk_wr("R8 w1", e0 + 1, 12'h100, 32'd2);
        chk_wr("R8 w2", e0 + 2, 12'h100, 32'd1);
        chk_wr("R8 w3", e0 + 3, 12'h200, 32'd0);
        chk_wr("R8 w4", e0 + 4, 12'h300, 32'd0);

        // R4 illegal function code
        set_alu(5'd13);
        load2(2, 32'd1, 32'd2);
        e0 = ecnt;
        kick(9'd0);
        wait_done("R4");
        check("R4 err set", 32'(err), 32'd1);
        check("R4 no write", 32'(ecnt - e0), 32'd0);

        // R10 stall on empty stream
        set_alu(5'd0);
        pgate = 1'b0;
        load2(2, 32'd11, 32'd22);
        e0 = ecnt;
        kick(9'd0);
        check("R4 err cleared by start", 32'(err), 32'd0);
        repeat (20) @(negedge clk);
        check("R10 stalled busy", {30'd0, busy, done}, 32'd2);
        check("R10 no write while stalled", 32'(ecnt - e0), 32'd0);
        pgate = 1'b1;
        wait_done("R10");
        chk_wr("R10 after stall", e0, 12'h010, 32'd33);

        // R10 exhausted stream reads zero
        pend_in = 1'b1;
        load2(0, 32'd0, 32'd0);
        e0 = ecnt;
        kick(9'd0);
        wait_done("R10 end");
        check("R10 end write count", 32'(ecnt - e0), 32'd1);
        chk_wr("R10 exhausted zero", e0, 12'h010, 32'd0);
        pend_in = 1'b0;

        summary();
        $finish;
    end

endmodule